// File: doc/BRIEF.md
# Clock SYNC Event Generator

This block decides when a clock distribution device must synchronize its outputs. It watches an external SYNC pin, the lock-detect flags of two PLLs, and a strobe that marks a write to the pulse-count register. An 8-bit control word selects how these sources are used. The block has two outputs. The first is a hold level, which keeps the output dividers in SYNC. The second is a single-cycle trigger for a separate SYSREF pulser.

The control word chooses the pin polarity and whether the pin acts by level or by edge. It can also hold SYNC while either PLL is unlocked, and a 2-bit mode sends each request either to the divider hold or to the pulser. The pin and both lock flags cross into the reference clock domain through two-flop synchronizers. The SYSREF clear bit is only stored and brought out on a port.

Top module: `sync_event_gen`

## Requirements
- R1: After reset the control word is 0x91: clear bit 1, enable 1, mode 1, all other bits 0. With the pin low, `sync_hold` and `pulser_trig` are 0 and `sysref_clr` is 1.
- R2: A write stores `ctrl_wdata` on the clock edge. The field positions are:
  - bit 7: SYSREF clear
  - bit 6: one-shot enable
  - bit 5: pin invert
  - bit 4: sync enable
  - bit 3: PLL2 lock hold
  - bit 2: PLL1 lock hold
  - bits 1:0: mode

  `sysref_clr` follows bit 7.
- R3: When pin invert is 1, the pin is inverted before any other processing. The qualified pin is `sync_pin` XOR the invert bit.
- R4: In mode 1 with one-shot off, `sync_hold` is high for exactly as many cycles as the qualified pin is high. It rises two clock edges after the pin rises.
- R5: In mode 1 with one-shot on, each rising edge of the qualified pin holds SYNC for exactly 4 cycles, whatever the pin width.
- R6: In mode 1, when a PLL lock-hold bit is 1 and that PLL's lock flag is 0, `sync_hold` stays high. It drops once the flag is 1. With the hold bit clear, the flag has no effect.
- R7: In mode 0, neither output ever asserts from the pin or from the lock flags.
- R8: In mode 2, `sync_hold` stays low. `pulser_trig` gives one single-cycle pulse for each rising edge of the qualified pin, and one for each rising edge of the lock-hold request.
- R9: In mode 3, `pulser_trig` pulses for one cycle on the edge after each `pulse_cnt_wr` cycle, including back-to-back strobes. The pin and the strobe in other modes give no trigger.
- R10: With the sync enable bit 0, neither output asserts, whatever the other bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pin | input | 1 | External SYNC request, asynchronous |
| pll1_lock | input | 1 | PLL1 lock-detect flag, asynchronous |
| pll2_lock | input | 1 | PLL2 lock-detect flag, asynchronous |
| pulse_cnt_wr | input | 1 | One-cycle strobe marking a pulse-count register write |
| ctrl_we | input | 1 | Control word write enable |
| ctrl_wdata | input | 8 | Control word write data |
| sync_hold | output | 1 | Holds the output dividers in SYNC |
| pulser_trig | output | 1 | Single-cycle trigger to the SYSREF pulser |
| sysref_clr | output | 1 | Stored SYSREF clear bit |

## Verification
A pin pulse of six cycles is applied under every combination of mode, polarity, one-shot and enable. For each combination the bench counts the held cycles and the trigger pulses. These counts tell level holds (six cycles) from one-shot holds (four cycles), and hold routing from pulser routing. They also show that polarity alone changes nothing once the pin is driven in its own sense. Separate patterns drop each lock flag with the matching hold bit set and with it clear, in direct, blocked and pulser modes. Register-write strobes are sent in every mode, including three in a row in mode 3, to tell the write-triggered path apart from the pin path.

// File: rtl/sync_gen_pkg.sv
// Shared types for the SYNC event generator.
// Assumes the control word layout is fixed by software and must not move.
package sync_gen_pkg;

    typedef enum logic [1:0] {
        MODE_OFF        = 2'd0,
        MODE_DIRECT     = 2'd1,
        MODE_PULSER_PIN = 2'd2,
        MODE_PULSER_WR  = 2'd3
    } sync_mode_e;

    typedef struct packed {
        logic       sysref_clr;
        logic       oneshot_en;
        logic       pin_inv;
        logic       sync_en;
        logic       hold_pll2;
        logic       hold_pll1;
        sync_mode_e mode;
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h91;

endpackage

// File: rtl/sync_gen_ctrl_reg.sv
// Control word storage.
// Loads on a write enable and returns to the reset word on a synchronous reset.
// Assumes the write data is already in the reference clock domain.
module sync_gen_ctrl_reg
    import sync_gen_pkg::*;
#(
    parameter int          WIDTH    = 8,
    parameter logic [7:0]  RST_WORD = CTRL_RESET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output ctrl_t            cfg
);

    logic [WIDTH-1:0] word_q;

    // Hold the control word; a write replaces it whole.
    always_ff @(posedge clk) begin
        if (!rst_n)  word_q <= RST_WORD;
        else if (we) word_q <= wdata;
    end

    assign cfg = ctrl_t'(word_q);

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) && $past(rst_n) |-> word_q == $past(wdata));

endmodule

// File: rtl/sync_gen_sync2.sv
// Multi-bit synchronizer built from independent flop chains.
// Each bit is treated as its own asynchronous level; bits are not coherent.
module sync_gen_sync2 #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift every bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/sync_gen_edge.sv
// Rising-edge detector on a synchronous level.
// Assumes the input is already in the clock domain.
module sync_gen_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic prev_q;

    // Remember the last level so that a low-to-high step can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;

endmodule

// File: rtl/sync_gen_oneshot.sv
// Fixed-length hold timer.
// A load starts or restarts a hold of HOLD_CYC cycles.
// Assumes HOLD_CYC is at least 1.
module sync_gen_oneshot #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active
);

    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Count the remaining hold cycles down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // R5
    load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active);

    // R5
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(cnt_q) == CNT_W'(1));

endmodule

// File: rtl/sync_event_gen.sv
// SYNC event generator top.
// Qualifies the pin and both lock flags, then routes each request either to
// the divider hold output (mode 1) or to a one-cycle pulser trigger (modes 2, 3).
// Assumes pulse_cnt_wr and the control write are synchronous to clk.
module sync_event_gen
    import sync_gen_pkg::*;
#(
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_pin,
    input  logic       pll1_lock,
    input  logic       pll2_lock,
    input  logic       pulse_cnt_wr,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    output logic       sync_hold,
    output logic       pulser_trig
    ,
    output logic       sysref_clr
);

    localparam int N_ASYNC = 3;

    ctrl_t              cfg;
    logic [N_ASYNC-1:0] async_s;
    logic               pin_s, lk1_s, lk2_s;
    logic               pin_qual, pin_rise;
    logic               lock_req, lock_rise;
    logic               os_active, level_req, direct_req;
    logic               trig_next;

    sync_gen_ctrl_reg #(.WIDTH(8), .RST_WORD(CTRL_RESET)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .cfg(cfg)
    );

    sync_gen_sync2 #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({pll2_lock, pll1_lock, sync_pin}),
        .sync_out(async_s)
    );

    assign {lk2_s, lk1_s, pin_s} = async_s;

    // Polarity is applied ahead of every other use of the pin.
    assign pin_qual = pin_s ^ cfg.pin_inv;
    assign lock_req = (cfg.hold_pll1 & ~lk1_s) | (cfg.hold_pll2 & ~lk2_s);

    sync_gen_edge u_pin_edge  (.clk(clk), .rst_n(rst_n), .level(pin_qual), .rise(pin_rise));
    sync_gen_edge u_lock_edge (.clk(clk), .rst_n(rst_n), .level(lock_req), .rise(lock_rise));

    sync_gen_oneshot #(.HOLD_CYC(HOLD_CYC)) u_oneshot (
        .clk(clk), .rst_n(rst_n),
        .load(cfg.oneshot_en & pin_rise),
        .active(os_active)
    );

    assign level_req  = ~cfg.oneshot_en & pin_qual;
    assign direct_req = level_req | os_active | lock_req;
    assign sync_hold  = cfg.sync_en & (cfg.mode == MODE_DIRECT) & direct_req;

    // Select the pulser trigger source by mode.
    always_comb begin
        unique case (cfg.mode)
            MODE_PULSER_PIN: trig_next = pin_rise | lock_rise;
            MODE_PULSER_WR:  trig_next = pulse_cnt_wr;
            default:         trig_next = 1'b0;
        endcase
        trig_next = trig_next & cfg.sync_en;
    end

    // Register the trigger so that it is a clean single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulser_trig <= 1'b0;
        else        pulser_trig <= trig_next;
    end

    assign sysref_clr = cfg.sysref_clr;

    // R10
    trig_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulser_trig && $past(rst_n) |-> $past(cfg.sync_en));

    // R7
    trig_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulser_trig && $past(rst_n) |-> $past(cfg.mode) inside {MODE_PULSER_PIN, MODE_PULSER_WR});

    // R9
    wr_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.sync_en && cfg.mode == MODE_PULSER_WR && pulse_cnt_wr && !ctrl_we |=> pulser_trig);

endmodule

// File: tb/tb_sync_event_gen.sv
module tb_sync_event_gen;

    localparam int CLK_PERIOD = 10;
    localparam int PULSE_W    = 6;
    localparam int WIN        = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_pin = 1'b0;
    logic       pll1_lock = 1'b1;
    logic       pll2_lock = 1'b1;
    logic       pulse_cnt_wr = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       sync_hold, pulser_trig, sysref_clr;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_event_gen dut (
        .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin),
        .pll1_lock(pll1_lock), .pll2_lock(pll2_lock),
        .pulse_cnt_wr(pulse_cnt_wr), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .sync_hold(sync_hold), .pulser_trig(pulser_trig), .sysref_clr(sysref_clr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count the held cycles and trigger pulses while the pin carries a
    // PULSE_W-cycle pulse in its own sense; also note the first held sample.
    task automatic pin_window(input bit inv, output int h, output int t, output int first);
        h = 0; t = 0; first = -1;
        for (int i = 0; i < WIN; i++) begin
            sync_pin = (i < PULSE_W) ? ~inv : inv;
            @(posedge clk); @(negedge clk);
            if (sync_hold) begin h++; if (first < 0) first = i; end
            if (pulser_trig) t++;
        end
    endtask

    task automatic count_window(input int n, output int h, output int t);
        h = 0; t = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            if (sync_hold) h++;
            if (pulser_trig) t++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int h, t, f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(4);
        // R1 reset word 0x91
        check(sysref_clr == 1'b1, "R1 sysref_clr", sysref_clr, 1);
        check(sync_hold == 1'b0, "R1 sync_hold", sync_hold, 0);
        check(pulser_trig == 1'b0, "R1 pulser_trig", pulser_trig, 0);
        // R1 reset mode is direct, level, enabled
        pin_window(1'b0, h, t, f);
        check(h == PULSE_W, "R1 reset mode level hold", h, PULSE_W);

        // R2 bit 7 reaches sysref_clr
        wr_ctrl(8'h11);
        check(sysref_clr == 1'b0, "R2 clear bit 0", sysref_clr, 0);
        wr_ctrl(8'h91);
        check(sysref_clr == 1'b1, "R2 clear bit 1", sysref_clr, 1);

        // Sweep: mode x invert x one-shot x enable (R3 R4 R5 R7 R8 R9 R10)
        for (int m = 0; m < 4; m++)
            for (int inv = 0; inv < 2; inv++)
                for (int os = 0; os < 2; os++)
                    for (int en = 0; en < 2; en++) begin
                        int eh, et;
                        sync_pin = inv[0];
                        wr_ctrl({1'b0, os[0], inv[0], en[0], 2'b00, m[1:0]});
                        idle(10);
                        pin_window(inv[0], h, t, f);
                        eh = (en == 1 && m == 1) ? (os == 1 ? 4 : PULSE_W) : 0;
                        et = (en == 1 && m == 2) ? 1 : 0;
                        check(h == eh, $sformatf("R3 R4 R5 R7 R10 hold m=%0d inv=%0d os=%0d en=%0d", m, inv, os, en), h, eh);
                        check(t == et, $sformatf("R8 R9 R10 trig m=%0d inv=%0d os=%0d en=%0d", m, inv, os, en), t, et);
                        if (eh == PULSE_W)
                            check(f == 1, "R4 hold latency", f, 1);
                        if (eh == 4)
                            check(f == 2, "R5 one-shot start", f, 2);
                    end
        sync_pin = 1'b0;

        // R9 strobe in each mode and enable
        for (int m = 0; m < 4; m++)
            for (int en = 0; en < 2; en++) begin
                int et;
                wr_ctrl({3'b000, en[0], 2'b00, m[1:0]});
                idle(6);
                @(negedge clk) pulse_cnt_wr = 1'b1;
                @(negedge clk) pulse_cnt_wr = 1'b0;
                if (pulser_trig) t = 1; else t = 0;
                count_window(4, h, f);
                t = t + f;
                et = (en == 1 && m == 3) ? 1 : 0;
                check(t == et, $sformatf("R9 R10 strobe m=%0d en=%0d", m, en), t, et);
            end

        // R9 back-to-back strobes
        wr_ctrl(8'h13);
        idle(4);
        @(negedge clk) pulse_cnt_wr = 1'b1;
        @(negedge clk);
        t = pulser_trig;
        @(negedge clk); t += pulser_trig;
        @(negedge clk) pulse_cnt_wr = 1'b0; t += pulser_trig;
        count_window(4, h, f);
        t += f;
        check(t == 3, "R9 back-to-back strobes", t, 3);

        // R6 PLL1 hold in mode 1
        wr_ctrl(8'h15);
        pll1_lock = 1'b0;
        idle(5);
        check(sync_hold == 1'b1, "R6 PLL1 unlocked holds", sync_hold, 1);
        pll1_lock = 1'b1;
        idle(4);
        check(sync_hold == 1'b0, "R6 PLL1 locked releases", sync_hold, 0);
        // R6 PLL2 hold
        wr_ctrl(8'h19);
        pll2_lock = 1'b0;
        idle(5);
        check(sync_hold == 1'b1, "R6 PLL2 unlocked holds", sync_hold, 1);
        pll2_lock = 1'b1;
        idle(4);
        check(sync_hold == 1'b0, "R6 PLL2 locked releases", sync_hold, 0);
        // R6 hold bits clear: flags ignored
        wr_ctrl(8'h11);
        pll1_lock = 1'b0; pll2_lock = 1'b0;
        count_window(8, h, t);
        check(h == 0, "R6 no hold bits", h, 0);
        // R7 mode 0 blocks lock holds
        wr_ctrl(8'h1C);
        count_window(8, h, t);
        check(h + t == 0, "R7 mode 0 lock blocked", h + t, 0);
        // R10 enable 0 blocks lock holds
        wr_ctrl(8'h0D);
        count_window(8, h, t);
        check(h + t == 0, "R10 disabled lock blocked", h + t, 0);
        pll1_lock = 1'b1; pll2_lock = 1'b1;
        // R8 lock drop in mode 2 fires the pulser once
        wr_ctrl(8'h16);
        idle(6);
        pll1_lock = 1'b0;
        count_window(10, h, t);
        check(t == 1, "R8 lock drop trig", t, 1);
        check(h == 0, "R8 no hold in pulser mode", h, 0);
        pll1_lock = 1'b1;
        idle(4);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule